// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This block is a one-channel copy engine driven by a chain of descriptors kept in memory. Each descriptor is a 32-byte record that gives a source address, a destination address, a byte count and a link to the following record. Software writes the address of the first record into the current-descriptor register and sets the start bit. The engine then reads the record into its working registers and copies the segment one byte per beat: a read from the source, then a write to the destination. When the segment is done it follows the link, and it stops after the record whose link carries the last-descriptor flag.

Software can halt the engine by clearing the start bit. A read or write response error halts it too, as does a descriptor address off a 32-byte boundary. An error also sets a sticky error flag, and the engine will not run again until software clears that flag by writing a one to it. While the engine is halted, every working register can be read and written. Setting start again resumes a segment that was cut short. Writing a new current-descriptor address discards that segment and makes the next start fetch a fresh descriptor.

Register map (3-bit index): 0 control (bit 0 start), 1 status (bit 0 busy, read only; bit 1 error, write one to clear), 2 current descriptor, 3 next descriptor, 4 source, 5 destination, 6 byte count.

Top module: `chain_dma`

## Requirements
- R1: After reset every register reads zero, the status reads zero and neither memory request is asserted.
- R2: A descriptor fetch makes four word reads at current+0x00, +0x08, +0x10 and +0x18. These load the source, destination, next-descriptor and byte-count registers, with the count taken from the low bits of the fourth word.
- R3: Each byte of a segment is read from the source address (data in bits 7:0) and then written to the destination address. A request is held with its address steady until it is acknowledged, and a read and a write are never requested together. After each write the source and destination go up by one and the count goes down by one.
- R4: A descriptor with a byte count of zero finishes its segment without any data read or write.
- R5: When a segment ends with bit 0 of the next-descriptor register at 0, the engine loads the current-descriptor register with that value (bit 0 cleared) and fetches from it. When bit 0 is 1, the engine clears start and busy and stops.
- R6: Clearing start halts the engine at the next byte boundary and clears busy. Setting start again completes the remaining bytes of the segment.
- R7: A descriptor address with any of bits 4:0 set raises the error flag and halts the engine without any read.
- R8: A read or write response error sets the error flag, clears start and halts the engine. The failed write does not count as a completed byte.
- R9: The error flag stays set until status bit 1 is written with a one. While it is set the engine stays idle even if start is 1, and it runs once the flag is cleared.
- R10: Writes to the current, next, source, destination and count registers are ignored while busy, and take effect while halted.
- R11: A write to the current-descriptor register while halted drops a partly copied segment, and the next start fetches a descriptor from the new address.
- R12: Busy is set from the cycle after start is seen until the chain completes, a halt or an error occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for reg_addr |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | AW | Read data |
| rd_err | input | 1 | Read response error, valid with rd_ack |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | AW | Memory write byte address |
| wr_data | output | 8 | Write data byte |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write response error, valid with wr_ack |

## Verification
The assertions check the following on every cycle: requests are held steady until acknowledged, reads and writes never overlap, the error flag is sticky, and a response error leaves the engine idle with the flag set. The order and content of the data writes across a chain come only from the bench scenarios. These include the skipped zero-count segment, halt and resume, the discarded segment after a new current-descriptor write, the refusal to run while the error flag is set, and the register values left at the end of each run.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int DESC_ALIGN_BITS = 5;
    localparam int FIELD_STRIDE    = 8;
    localparam int NUM_FIELDS      = 4;
    localparam int IDX_W           = $clog2(NUM_FIELDS);

    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_STAT = 3'd1;
    localparam logic [2:0] REG_CUR  = 3'd2;
    localparam logic [2:0] REG_NEXT = 3'd3;
    localparam logic [2:0] REG_SRC  = 3'd4;
    localparam logic [2:0] REG_DST  = 3'd5;
    localparam logic [2:0] REG_CNT  = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISP,
        ST_FETCH,
        ST_RD,
        ST_WR
    } eng_state_t;

    function automatic logic low_bits_clear(input logic [DESC_ALIGN_BITS-1:0] low);
        return low == '0;
    endfunction
endpackage

// File: rtl/dma_fetch_addr.sv
module dma_fetch_addr
    import dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    cur,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr,
    output logic             aligned
);
    always_comb begin
        addr    = cur + AW'(idx) * AW'(FIELD_STRIDE);
        aligned = low_bits_clear(cur[DESC_ALIGN_BITS-1:0]);
    end
endmodule

// File: rtl/dma_reg_rmux.sv
module dma_reg_rmux
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic [2:0]    sel,
    input  logic          start,
    input  logic          busy,
    input  logic          err,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] nxt,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [CW-1:0] cnt,
    output logic [AW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (sel)
            REG_CTRL: rdata[0] = start;
            REG_STAT: begin
                rdata[0] = busy;
                rdata[1] = err;
            end
            REG_CUR:  rdata = cur;
            REG_NEXT: rdata = nxt;
            REG_SRC:  rdata = src;
            REG_DST:  rdata = dst;
            REG_CNT:  rdata = AW'(cnt);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [AW-1:0] rd_data,
    input  logic          rd_err,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    input  logic          wr_ack,
    input  logic          wr_err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FIELDS - 1);

    eng_state_t       state_q;
    logic             start_q, err_q, loaded_q;
    logic [AW-1:0]    cur_q, next_q, src_q, dst_q;
    logic [CW-1:0]    cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       byte_q;

    logic [AW-1:0] fetch_addr;
    logic          cur_aligned;
    logic          busy;
    logic          halted;
    logic          sw_wr_cur, sw_wr_next, sw_wr_src, sw_wr_dst, sw_wr_cnt;

    dma_fetch_addr #(.AW(AW)) u_faddr (
        .cur     (cur_q),
        .idx     (idx_q),
        .addr    (fetch_addr),
        .aligned (cur_aligned)
    );

    assign busy   = (state_q != ST_IDLE);
    assign halted = !busy;

    dma_reg_rmux #(.AW(AW), .CW(CW)) u_rmux (
        .sel   (reg_addr),
        .start (start_q),
        .busy  (busy),
        .err   (err_q),
        .cur   (cur_q),
        .nxt   (next_q),
        .src   (src_q),
        .dst   (dst_q),
        .cnt   (cnt_q),
        .rdata (reg_rdata)
    );

    assign sw_wr_cur  = reg_wr && halted && reg_addr == REG_CUR;
    assign sw_wr_next = reg_wr && halted && reg_addr == REG_NEXT;
    assign sw_wr_src  = reg_wr && halted && reg_addr == REG_SRC;
    assign sw_wr_dst  = reg_wr && halted && reg_addr == REG_DST;
    assign sw_wr_cnt  = reg_wr && halted && reg_addr == REG_CNT;

    always_comb begin
        rd_req  = (state_q == ST_FETCH) || (state_q == ST_RD);
        rd_addr = (state_q == ST_FETCH) ? fetch_addr : src_q;
        wr_req  = (state_q == ST_WR);
        wr_addr = dst_q;
        wr_data = byte_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            start_q  <= 1'b0;
            err_q    <= 1'b0;
            loaded_q <= 1'b0;
            cur_q    <= '0;
            next_q   <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            idx_q    <= '0;
            byte_q   <= '0;
        end else begin
            // software side first; engine updates below take priority
            if (reg_wr && reg_addr == REG_CTRL) start_q <= reg_wdata[0];
            if (reg_wr && reg_addr == REG_STAT && reg_wdata[1]) err_q <= 1'b0;
            if (sw_wr_cur) begin
                cur_q    <= reg_wdata;
                loaded_q <= 1'b0;
            end
            if (sw_wr_next) next_q <= reg_wdata;
            if (sw_wr_src)  src_q  <= reg_wdata;
            if (sw_wr_dst)  dst_q  <= reg_wdata;
            if (sw_wr_cnt)  cnt_q  <= reg_wdata[CW-1:0];

            unique case (state_q)
                ST_IDLE: begin
                    if (start_q && !err_q) state_q <= ST_DISP;
                end
                ST_DISP: begin
                    if (!start_q) begin
                        state_q <= ST_IDLE;
                    end else if (loaded_q && cnt_q == '0) begin
                        loaded_q <= 1'b0;
                        if (next_q[0]) begin
                            start_q <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            cur_q <= {next_q[AW-1:1], 1'b0};
                        end
                    end else if (loaded_q) begin
                        state_q <= ST_RD;
                    end else if (!cur_aligned) begin
                        err_q   <= 1'b1;
                        start_q <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        idx_q   <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (rd_ack) begin
                        if (rd_err) begin
                            err_q   <= 1'b1;
                            start_q <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            case (idx_q)
                                2'd0:    src_q  <= rd_data;
                                2'd1:    dst_q  <= rd_data;
                                2'd2:    next_q <= rd_data;
                                default: cnt_q  <= rd_data[CW-1:0];
                            endcase
                            idx_q <= idx_q + 1'b1;
                            if (idx_q == LAST_IDX) begin
                                loaded_q <= 1'b1;
                                state_q  <= ST_DISP;
                            end
                        end
                    end
                end
                ST_RD: begin
                    if (rd_ack) begin
                        if (rd_err) begin
                            err_q   <= 1'b1;
                            start_q <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            byte_q  <= rd_data[7:0];
                            state_q <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (wr_ack) begin
                        if (wr_err) begin
                            err_q   <= 1'b1;
                            start_q <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            src_q   <= src_q + 1'b1;
                            dst_q   <= dst_q + 1'b1;
                            cnt_q   <= cnt_q - 1'b1;
                            state_q <= ST_DISP;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          err_q,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [AW-1:0] reg_wdata,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ack,
    input logic          rd_err,
    input logic          wr_req,
    input logic [AW-1:0] wr_addr,
    input logic          wr_ack,
    input logic          wr_err
);
    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr));

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q && !(reg_wr && reg_addr == 3'd1 && reg_wdata[1]) |=> err_q);

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !busy);

    // R8
    rd_fault_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && rd_ack && rd_err |=> err_q && !busy);

    // R8
    wr_fault_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req && wr_ack && wr_err |=> err_q && !busy);
endmodule

bind chain_dma dma_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .err_q     (err_q),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .rd_err    (rd_err),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_ack    (wr_ack),
    .wr_err    (wr_err)
);

// File: tb/sim_chain_dma.sv
`timescale 1ns/1ps
module sim_chain_dma;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          rd_req, wr_req;
    logic [AW-1:0] rd_addr, wr_addr, rd_data;
    logic [7:0]    wr_data;
    logic          rd_ack = 1'b0, wr_ack = 1'b0;
    logic          rd_err, wr_err;

    logic [7:0]    mem [0:1023];
    logic [AW-1:0] bad_rd = 32'hFFFF_FFFF;
    logic [AW-1:0] bad_wr = 32'hFFFF_FFFF;

    int total = 0, bad = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [39:0] expq [$];

    always #2.5 clk = ~clk;

    chain_dma u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .rd_err(rd_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack), .wr_err(wr_err)
    );

    // memory model
    always_comb begin
        rd_data = {mem[10'(rd_addr + 3)], mem[10'(rd_addr + 2)],
                   mem[10'(rd_addr + 1)], mem[10'(rd_addr[9:0])]};
        rd_err  = rd_ack && (rd_addr == bad_rd);
        wr_err  = wr_ack && (wr_addr == bad_wr);
    end

    always @(posedge clk) begin
        if (rst) begin
            rd_ack <= 1'b0;
            wr_ack <= 1'b0;
        end else begin
            rd_ack <= rd_req && !rd_ack;
            wr_ack <= wr_req && !wr_ack;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // write stream reference: compared on every clock
    always @(negedge clk) begin
        if (!rst && rd_req && rd_ack) rd_cnt++;
        if (!rst && wr_req && wr_ack && !wr_err) begin
            if (expq.size() == 0) begin
                chk("R3 unexpected write", {wr_addr[23:0], wr_data}, 32'h0);
            end else begin
                chk("R3 write addr/data", {wr_addr[23:0], wr_data}, expq[0][31:0]);
                void'(expq.pop_front());
            end
            mem[wr_addr[9:0]] = wr_data;
            wr_cnt++;
        end
    end

    task automatic put_word(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[10'(a + k)] = v[8*k +: 8];
    endtask

    task automatic put_desc(input int a, input int s, input int d, input int n, input int c);
        put_word(a, s); put_word(a + 8, d); put_word(a + 16, n); put_word(a + 24, c);
    endtask

    task automatic expect_seg(input int s, input int d, input int from, input int c);
        for (int k = from; k < c; k++)
            expq.push_back({8'h0, 24'(d + k), mem[10'(s + k)]});
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int n = 0;
        rd_reg(3'd1, s);
        while (s[0] && n < 5000) begin
            rd_reg(3'd1, s);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base, rbase;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        put_desc('h100, 'h200, 'h300, 'h120, 5);
        put_desc('h120, 'h000, 'h000, 'h140, 0);
        put_desc('h140, 'h210, 'h320, 'h001, 3);
        put_desc('h180, 'h240, 'h380, 'h001, 20);
        put_desc('h1A0, 'h260, 'h3C0, 'h001, 16);

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        for (int r = 0; r < 7; r++) begin
            rd_reg(3'(r), v);
            chk("R1 register after reset", v, 0);
        end
        chk("R1 no requests after reset", {30'd0, rd_req, wr_req}, 0);

        // R2 R4 R5 chain of three, middle one zero length
        expect_seg('h200, 'h300, 0, 5);
        expect_seg('h210, 'h320, 0, 3);
        rbase = rd_cnt;
        wr_reg(3'd2, 'h100);
        wr_reg(3'd0, 1);
        rd_reg(3'd1, v);
        chk("R12 busy after start", v[0], 1);
        wait_idle();
        chk("R4 read count of chain", rd_cnt - rbase, 20);
        chk("R5 all writes done", expq.size(), 0);
        rd_reg(3'd0, v); chk("R5 start cleared at end", v, 0);
        rd_reg(3'd2, v); chk("R5 current is last descriptor", v, 'h140);
        rd_reg(3'd3, v); chk("R2 next loaded", v, 'h001);
        rd_reg(3'd4, v); chk("R3 source advanced", v, 'h213);
        rd_reg(3'd5, v); chk("R3 destination advanced", v, 'h323);
        rd_reg(3'd6, v); chk("R3 count at zero", v, 0);

        // R7 misaligned descriptor
        rbase = rd_cnt;
        wr_reg(3'd2, 'h104);
        wr_reg(3'd0, 1);
        repeat (6) @(negedge clk);
        rd_reg(3'd1, v); chk("R7 error set, not busy", v, 2);
        chk("R7 no read issued", rd_cnt - rbase, 0);
        wr_reg(3'd1, 2);
        rd_reg(3'd1, v); chk("R9 error cleared by write one", v, 0);

        // R6 R10 halt, ignored write while busy, resume
        expect_seg('h240, 'h380, 0, 20);
        base = wr_cnt;
        wr_reg(3'd2, 'h180);
        wr_reg(3'd0, 1);
        wr_reg(3'd4, 'h3F0);
        while (wr_cnt < base + 4) @(negedge clk);
        wr_reg(3'd0, 0);
        wait_idle();
        rd_reg(3'd6, v);
        chk("R6 remaining count after halt", v, 20 - (wr_cnt - base));
        chk("R6 halted mid segment", (v > 0 && v < 20), 1);
        wr_reg(3'd0, 1);
        wait_idle();
        chk("R6 resume finished segment", expq.size(), 0);
        chk("R6 total bytes", wr_cnt - base, 20);
        rd_reg(3'd4, v); chk("R10 source write while busy ignored", v, 'h240 + 20);
        wr_reg(3'd5, 'h3A5);
        rd_reg(3'd5, v); chk("R10 write while halted accepted", v, 'h3A5);

        // R11 new descriptor address drops partial segment
        expect_seg('h260, 'h3C0, 0, 16);
        base = wr_cnt;
        wr_reg(3'd2, 'h1A0);
        wr_reg(3'd0, 1);
        while (wr_cnt < base + 3) @(negedge clk);
        wr_reg(3'd0, 0);
        wait_idle();
        expq.delete();
        expect_seg('h210, 'h320, 0, 3);
        wr_reg(3'd2, 'h140);
        wr_reg(3'd0, 1);
        wait_idle();
        chk("R11 fresh fetch writes", expq.size(), 0);
        rd_reg(3'd4, v); chk("R11 source from new descriptor", v, 'h213);

        // R8 R9 read error, refusal, resume after clear
        bad_rd = 'h262;
        expect_seg('h260, 'h3C0, 0, 2);
        wr_reg(3'd2, 'h1A0);
        wr_reg(3'd0, 1);
        wait_idle();
        rd_reg(3'd1, v); chk("R8 read error flag", v, 2);
        rd_reg(3'd0, v); chk("R8 start cleared on error", v, 0);
        chk("R8 bytes before error", expq.size(), 0);
        rbase = rd_cnt;
        wr_reg(3'd0, 1);
        repeat (8) @(negedge clk);
        rd_reg(3'd1, v); chk("R9 stays idle while error set", v, 2);
        chk("R9 no reads while error set", rd_cnt - rbase, 0);
        bad_rd = 32'hFFFF_FFFF;
        expect_seg('h260, 'h3C0, 2, 16);
        wr_reg(3'd1, 2);
        repeat (2) @(negedge clk);
        wait_idle();
        chk("R9 runs after clear", expq.size(), 0);
        rd_reg(3'd1, v); chk("R9 status after resumed run", v, 0);

        // R8 write error
        bad_wr = 'h321;
        expect_seg('h210, 'h320, 0, 1);
        wr_reg(3'd2, 'h140);
        wr_reg(3'd0, 1);
        wait_idle();
        rd_reg(3'd1, v); chk("R8 write error flag", v, 2);
        rd_reg(3'd6, v); chk("R8 failed write not counted", v, 2);
        chk("R8 writes before error", expq.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule